// File: doc/BRIEF.md
# Masked Vector Reduction Unit

This block folds the active elements of one source vector into a single scalar. It works on up to `MAX_ELEMS` integer elements of `ELEM_W` bits each. A caller presents the source vector, a seed operand whose element 0 starts the accumulation, an optional per-element enable mask, the requested element count and an operation code. The caller then pulses `start`. The unit latches every operand on that edge and walks the elements one per cycle. It pulses `done` when the scalar has settled in element 0 of `dstOut`.

The remaining elements of `dstOut` repeat the destination contents presented at start, so the caller can write the whole vector back without corrupting it. A strip-mined loop can feed element 0 of the last result back as the next seed, and the partial results then accumulate across iterations.

Top module: `rdx_unit`

## Requirements
- R1: With `opSel` = 0 the result is the seed plus every active element, wrapping modulo 2^ELEM_W.
- R2: With `opSel` = 1 the result is the signed maximum of the seed and the active elements. With `opSel` = 2 it is the signed minimum. Both compare in two's complement.
- R3: With `opSel` = 3, 4 or 5 the result is the bitwise AND, OR or XOR of the seed and the active elements. Codes 6 and 7 return the seed unchanged.
- R4: With `maskEn` = 1, element i (bits i*ELEM_W upward of `srcVec`) takes part only when `mask[i]` is 1. With `maskEn` = 0, every element below the count takes part.
- R5: When the count is 0, or every element below the count is masked off, the result equals the seed.
- R6: Only elements 0 to count-1 take part. A requested count above `MAX_ELEMS` is treated as `MAX_ELEMS`.
- R7: Elements 1 and up of `dstOut` equal the matching elements of `dstIn` sampled at start. Element 0 carries the result.
- R8: Let the effective count be the count after the limit of R6. `done` is high for exactly one cycle, effective count + 1 cycles after the start edge, which is within VL+2 cycles. `busy` is high from the start edge until `done` rises.
- R9: All operands are captured at the start edge. A `start` while `busy` is ignored, and so are operand changes during a run.
- R10: The result stays on `dstOut` after `done` until the next accepted start. Feeding element 0 back as the seed accumulates across calls.
- R11: After reset `busy` and `done` are 0 and `dstOut` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a reduction (accepted only when idle) |
| opSel | input | 3 | Operation: 0 sum, 1 max, 2 min, 3 and, 4 or, 5 xor, 6/7 pass seed |
| maskEn | input | 1 | 1 = use `mask`, 0 = all elements active |
| mask | input | MAX_ELEMS | Per-element enable, bit i for element i |
| vl | input | $clog2(MAX_ELEMS+1) | Requested element count |
| srcVec | input | MAX_ELEMS*ELEM_W | Source elements, element 0 in the low bits |
| seedVec | input | MAX_ELEMS*ELEM_W | Seed operand; only element 0 is used |
| dstIn | input | MAX_ELEMS*ELEM_W | Present destination contents |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle pulse, result valid |
| dstOut | output | MAX_ELEMS*ELEM_W | Destination: result in element 0, others from `dstIn` |

## Verification
The hardest case to reach from the ports is a second `start`, together with fresh operands, arriving while a run is still stepping. That stimulus must leave both the timing and the result of the first run untouched. The bench raises `start` one cycle into the run and, in the same cycle, inverts the source, seed and destination inputs and changes the operation code. It then expects the original result on schedule. Mask patterns that leave only the top element active, or none at all, and counts of zero and above the limit, cover the edges of the stepping window.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

  typedef enum logic [2:0] {
    OP_SUM   = 3'd0,
    OP_MAX   = 3'd1,
    OP_MIN   = 3'd2,
    OP_AND   = 3'd3,
    OP_OR    = 3'd4,
    OP_XOR   = 3'd5,
    OP_PASSA = 3'd6,
    OP_PASSB = 3'd7
  } rdxOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture operands, seed accumulator
    logic step;    // fold element at current index
    logic finish;  // run complete
  } rdxStrobe_t;

endpackage

// File: rtl/rdx_ctrl.sv
module rdx_ctrl
  import rdx_pkg::*;
#(
  parameter int MAX_ELEMS = 8,
  parameter int VLW       = $clog2(MAX_ELEMS + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [VLW-1:0] vl,
  output rdxStrobe_t     strobe,
  output logic [VLW-1:0] idx,
  output logic           busy,
  output logic           done
);

  localparam logic [VLW-1:0] MAX_VL = VLW'(MAX_ELEMS);

  typedef enum logic {S_IDLE, S_RUN} state_e;

  state_e         state;
  logic [VLW-1:0] vlReg;
  logic [VLW-1:0] vlClamp;

  assign vlClamp = (vl > MAX_VL) ? MAX_VL : vl;
  assign busy    = (state == S_RUN);

  always_comb begin
    strobe = '0;
    unique case (state)
      S_IDLE: strobe.load = start;
      S_RUN: begin
        if (idx == vlReg) strobe.finish = 1'b1;
        else              strobe.step   = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx   <= '0;
      vlReg <= '0;
      done  <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.load) begin
        state <= S_RUN;
        idx   <= '0;
        vlReg <= vlClamp;
      end
      if (strobe.step)   idx   <= idx + 1'b1;
      if (strobe.finish) state <= S_IDLE;
    end
  end

endmodule

// File: rtl/rdx_datapath.sv
module rdx_datapath
  import rdx_pkg::*;
#(
  parameter int MAX_ELEMS = 8,
  parameter int ELEM_W    = 16,
  parameter int VLW       = $clog2(MAX_ELEMS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rdxStrobe_t                  strobe,
  input  logic [VLW-1:0]              idx,
  input  logic [2:0]                  opSel,
  input  logic                        maskEn,
  input  logic [MAX_ELEMS-1:0]        mask,
  input  logic [MAX_ELEMS*ELEM_W-1:0] srcVec,
  input  logic [MAX_ELEMS*ELEM_W-1:0] seedVec,
  input  logic [MAX_ELEMS*ELEM_W-1:0] dstIn,
  output logic [MAX_ELEMS*ELEM_W-1:0] dstOut
);

  localparam int VEC_W = MAX_ELEMS * ELEM_W;
  localparam int SELW  = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1;

  logic [VEC_W-1:0]     srcReg;
  logic [VEC_W-1:0]     dstReg;
  logic [MAX_ELEMS-1:0] enReg;
  rdxOp_e               opReg;
  logic [ELEM_W-1:0]    acc;
  logic [ELEM_W-1:0]    accNext;
  logic [ELEM_W-1:0]    srcArr [MAX_ELEMS];
  logic [SELW-1:0]      sel;
  logic [ELEM_W-1:0]    curElem;
  logic                 curOn;

  // Unpack the captured source vector into an element array
  for (genvar g = 0; g < MAX_ELEMS; g++) begin : g_unpack
    assign srcArr[g] = srcReg[g*ELEM_W +: ELEM_W];
  end

  assign sel     = idx[SELW-1:0];
  assign curElem = srcArr[sel];
  assign curOn   = enReg[sel];

  always_comb begin
    unique case (opReg)
      OP_SUM: accNext = acc + curElem;
      OP_MAX: accNext = ($signed(curElem) > $signed(acc)) ? curElem : acc;
      OP_MIN: accNext = ($signed(curElem) < $signed(acc)) ? curElem : acc;
      OP_AND: accNext = acc & curElem;
      OP_OR:  accNext = acc | curElem;
      OP_XOR: accNext = acc ^ curElem;
      default: accNext = acc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg <= '0;
      dstReg <= '0;
      enReg  <= '0;
      opReg  <= OP_SUM;
      acc    <= '0;
    end else if (strobe.load) begin
      srcReg <= srcVec;
      dstReg <= dstIn;
      enReg  <= maskEn ? mask : '1;
      opReg  <= rdxOp_e'(opSel);
      acc    <= seedVec[ELEM_W-1:0];
    end else if (strobe.step && curOn) begin
      acc <= accNext;
    end
  end

  assign dstOut = {dstReg[VEC_W-1:ELEM_W], acc};

endmodule

// File: rtl/rdx_unit.sv
module rdx_unit
  import rdx_pkg::*;
#(
  parameter int MAX_ELEMS = 8,
  parameter int ELEM_W    = 16,
  parameter int VLW       = $clog2(MAX_ELEMS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [2:0]                  opSel,
  input  logic                        maskEn,
  input  logic [MAX_ELEMS-1:0]        mask,
  input  logic [VLW-1:0]              vl,
  input  logic [MAX_ELEMS*ELEM_W-1:0] srcVec,
  input  logic [MAX_ELEMS*ELEM_W-1:0] seedVec,
  input  logic [MAX_ELEMS*ELEM_W-1:0] dstIn,
  output logic                        busy,
  output logic                        done,
  output logic [MAX_ELEMS*ELEM_W-1:0] dstOut
);

  rdxStrobe_t     strobe;
  logic [VLW-1:0] idx;

  rdx_ctrl #(.MAX_ELEMS(MAX_ELEMS), .VLW(VLW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .vl(vl),
    .strobe(strobe), .idx(idx), .busy(busy), .done(done)
  );

  rdx_datapath #(.MAX_ELEMS(MAX_ELEMS), .ELEM_W(ELEM_W), .VLW(VLW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(idx),
    .opSel(opSel), .maskEn(maskEn), .mask(mask),
    .srcVec(srcVec), .seedVec(seedVec), .dstIn(dstIn), .dstOut(dstOut)
  );

endmodule

// File: rtl/rdx_checker.sv
module rdx_checker #(
  parameter int MAX_ELEMS = 8,
  parameter int ELEM_W    = 16,
  parameter int VLW       = $clog2(MAX_ELEMS + 1)
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        start,
  input logic                        busy,
  input logic                        done,
  input logic [MAX_ELEMS*ELEM_W-1:0] seedVec,
  input logic [MAX_ELEMS*ELEM_W-1:0] dstOut
);

  logic [VLW:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               runCnt <= '0;
    else if (start && !busy) runCnt <= '0;
    else if (busy)           runCnt <= runCnt + 1'b1;
  end

  p_run_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runCnt <= (VLW+1)'(MAX_ELEMS)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_after_run_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  p_run_ends_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));

  p_upper_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(dstOut[MAX_ELEMS*ELEM_W-1:ELEM_W]));

  p_seed_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (dstOut[ELEM_W-1:0] == $past(seedVec[ELEM_W-1:0])));

endmodule

bind rdx_unit rdx_checker #(.MAX_ELEMS(MAX_ELEMS), .ELEM_W(ELEM_W), .VLW(VLW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .seedVec(seedVec), .dstOut(dstOut)
);

// File: tb/tb_rdx_unit.sv
`timescale 1ns/1ps
module tb_rdx_unit;

  localparam int N   = 8;
  localparam int W   = 16;
  localparam int VLW = $clog2(N + 1);
  localparam int VW  = N * W;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [2:0]     opSel = '0;
  logic           maskEn = 1'b0;
  logic [N-1:0]   mask = '0;
  logic [VLW-1:0] vl = '0;
  logic [VW-1:0]  srcVec = '0;
  logic [VW-1:0]  seedVec = '0;
  logic [VW-1:0]  dstIn = '0;
  logic           busy;
  logic           done;
  logic [VW-1:0]  dstOut;

  int checks = 0;
  int failures = 0;
  logic [VW-1:0] lastDst;

  always #5 clk = ~clk;

  rdx_unit #(.MAX_ELEMS(N), .ELEM_W(W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .maskEn(maskEn),
    .mask(mask), .vl(vl), .srcVec(srcVec), .seedVec(seedVec), .dstIn(dstIn),
    .busy(busy), .done(done), .dstOut(dstOut)
  );

  task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] refReduce(input logic [2:0] op, input logic me,
      input logic [N-1:0] mk, input int cnt, input logic [VW-1:0] s, input logic [W-1:0] sd);
    logic [W-1:0] a;
    logic [W-1:0] e;
    a = sd;
    for (int i = 0; i < cnt; i++) begin
      e = s[i*W +: W];
      if (!me || mk[i]) begin
        case (op)
          3'd0: a = a + e;
          3'd1: if ($signed(e) > $signed(a)) a = e;
          3'd2: if ($signed(e) < $signed(a)) a = e;
          3'd3: a = a & e;
          3'd4: a = a | e;
          3'd5: a = a ^ e;
          default: a = a;
        endcase
      end
    end
    return a;
  endfunction

  task automatic runOp(input string tag, input logic [2:0] op, input logic me,
      input logic [N-1:0] mk, input logic [VLW-1:0] v, input logic [VW-1:0] s,
      input logic [W-1:0] sd, input logic [VW-1:0] di, input bit disturb);
    int effVl;
    logic [W-1:0] expRes;
    logic [VW-1:0] expDst;
    effVl  = (int'(v) > N) ? N : int'(v);
    expRes = refReduce(op, me, mk, effVl, s, sd);
    expDst = {di[VW-1:W], expRes};
    @(negedge clk);
    opSel = op; maskEn = me; mask = mk; vl = v; srcVec = s;
    seedVec = {{(VW-W){1'b1}}, sd}; dstIn = di; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= effVl + 2; k++) begin
      if (k > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      check({tag, " R8 busy"}, VW'(busy), VW'(k <= effVl));
      check({tag, " R8 done"}, VW'(done), VW'(k == effVl + 1));
      if (k == effVl + 1) check({tag, " R7 dstOut"}, dstOut, expDst);
      if (disturb && effVl >= 1 && k == 1) begin
        start = 1'b1; srcVec = ~s; seedVec = ~seedVec; dstIn = ~di;
        opSel = op ^ 3'd1; mask = ~mk; vl = '0;
      end
      if (disturb && k == 2) start = 1'b0;
    end
    start = 1'b0;
    lastDst = expDst;
  endtask

  initial begin
    #(10 * 150000);
    failures++;
    $display("FAIL watchdog timeout actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [VW-1:0] s;
    logic [VW-1:0] d;
    s = {16'h0007, 16'h8000, 16'hFFFF, 16'h1234, 16'h7FFF, 16'h0001, 16'hF00F, 16'h00F0};
    d = {16'hA7A7, 16'hA6A6, 16'hA5A5, 16'hA4A4, 16'hA3A3, 16'hA2A2, 16'hA1A1, 16'hA0A0};
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 busy", VW'(busy), '0);
    check("R11 done", VW'(done), '0);
    check("R11 dstOut", dstOut, '0);
    rstN = 1'b1;

    runOp("R1 sum wrap", 3'd0, 1'b0, '0, 4'd8, s, 16'hFFF0, d, 1'b0);
    runOp("R2 max", 3'd1, 1'b0, '0, 4'd8, s, 16'h8001, d, 1'b0);
    runOp("R2 min", 3'd2, 1'b0, '0, 4'd8, s, 16'h0000, d, 1'b0);
    runOp("R2 max neg seed wins", 3'd1, 1'b0, '0, 4'd2, {VW{1'b1}}, 16'h0005, d, 1'b0);
    runOp("R3 and", 3'd3, 1'b0, '0, 4'd8, {8{16'hF0FF}}, 16'hFFF3, d, 1'b0);
    runOp("R3 or", 3'd4, 1'b0, '0, 4'd8, s, 16'h0000, d, 1'b0);
    runOp("R3 xor", 3'd5, 1'b0, '0, 4'd8, s, 16'h5555, d, 1'b0);
    runOp("R3 code6 pass", 3'd6, 1'b0, '0, 4'd8, s, 16'h1357, d, 1'b0);
    runOp("R3 code7 pass", 3'd7, 1'b0, '0, 4'd8, s, 16'h2468, d, 1'b0);
    runOp("R4 masked sum", 3'd0, 1'b1, 8'b1010_0110, 4'd8, s, 16'h0010, d, 1'b0);
    runOp("R4 top only", 3'd4, 1'b1, 8'b1000_0000, 4'd8, s, 16'h0000, d, 1'b0);
    runOp("R4 mask ignored", 3'd0, 1'b0, 8'b0000_0001, 4'd8, s, 16'h0000, d, 1'b0);
    runOp("R5 vl zero", 3'd0, 1'b0, '0, 4'd0, s, 16'hBEEF, d, 1'b0);
    runOp("R5 all masked", 3'd5, 1'b1, 8'h00, 4'd8, s, 16'hCAFE, d, 1'b0);
    runOp("R6 tail vl5", 3'd0, 1'b0, '0, 4'd5, s, 16'h0000, d, 1'b0);
    runOp("R6 clamp vl12", 3'd0, 1'b0, '0, 4'd12, s, 16'h0003, d, 1'b0);
    runOp("R9 start ignored", 3'd0, 1'b1, 8'b0111_1101, 4'd6, s, 16'h0100, d, 1'b1);

    // R10 hold after done
    repeat (4) @(negedge clk);
    check("R10 hold", dstOut, lastDst);

    // R10 chaining: previous result element 0 becomes next seed
    runOp("R10 chain a", 3'd0, 1'b0, '0, 4'd8, {8{16'h0011}}, 16'h0000, d, 1'b0);
    runOp("R10 chain b", 3'd0, 1'b0, '0, 4'd8, {8{16'h0011}}, dstOut[W-1:0], d, 1'b0);
    check("R10 chained total", VW'(dstOut[W-1:0]), VW'(16'h0110));

    for (int r = 0; r < 24; r++) begin
      logic [VW-1:0] rs;
      for (int j = 0; j < N; j++) rs[j*W +: W] = W'($urandom);
      runOp("R1 R2 R3 R4 random", 3'($urandom_range(0, 7)), 1'($urandom),
            N'($urandom), VLW'($urandom_range(0, 9)), rs, W'($urandom),
            {N{W'($urandom)}}, (r % 4) == 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule